// File: doc/BRIEF.md
# Memory-Operand Micro-op Cracker

This block takes one decoded ALU instruction descriptor at a time and expands it into a short, ordered run of internal micro-ops for the out-of-order back end. The descriptor gives:
- the ALU opcode,
- the operand form (register-register, memory source with a register destination, or memory destination),
- the destination and source register numbers,
- a tag that names the already-prepared address operand.

Instructions that touch memory are split into their parts. A load brings memory into a reserved temporary register, the ALU step works on registers, and a store is either split into address and data halves or kept as one fused store.

A mode input selects between fused and unfused cracking. In fused mode the load travels with its ALU step as one micro-op, and the store address and data travel as one micro-op. Each instruction then takes fewer reorder-buffer slots. Unfused mode exists to compare the two. Every micro-op carries first and last markers, together with the total slot count of its instruction. Output uses a valid/ready handshake: one micro-op per cycle, held stable while the consumer stalls.

Top module: `memop_cracker`

## Requirements
- R1: After reset `outValid` is 0 and `inReady` is 1.
- R2: A register-register descriptor (`inForm`=0) gives one micro-op of kind 0 (ALU) in either mode, with dst=D, srcA=D, srcB=S, tag=0 and `outSlots`=1. Here D, S and T are the descriptor's destination, source and tag. Unused fields are always 0, and `outOp` always carries the descriptor opcode.
- R3: In fused mode a memory-source descriptor (`inForm`=1) gives one micro-op of kind 2 (load+ALU) with dst=D, srcA=D, srcB=0, tag=T and `outSlots`=1.
- R4: In unfused mode `inForm`=1 gives two micro-ops, with `outSlots`=2:
  - kind 1 (load): dst=TMP, tag=T;
  - kind 0 (ALU): dst=D, srcA=D, srcB=TMP.
- R5: In fused mode a memory-destination descriptor (`inForm`=2) gives two micro-ops, with `outSlots`=2:
  - kind 2: dst=TMP, srcA=S, tag=T;
  - kind 5 (fused store): srcB=TMP, tag=T.
- R6: In unfused mode `inForm`=2 gives four micro-ops, with `outSlots`=4:
  - kind 1 load: dst=TMP, tag=T;
  - kind 0 ALU: dst=TMP, srcA=TMP, srcB=S;
  - kind 3 store-address: tag=T;
  - kind 4 store-data: srcB=TMP, tag=T.
- R7: While `outValid` is high and `outReady` is low, every output field holds its value into the next cycle.
- R8: `inReady` is low from the cycle after a descriptor is accepted until the cycle after its last micro-op is taken. `inValid` presented while `inReady` is low is ignored.
- R9: `outFirst` is 1 only on the first micro-op of an instruction, and `outLast` is 1 only on its last micro-op.
- R10: `fuseEn` is sampled when the descriptor is accepted. Changing it during a sequence has no effect on that sequence.
- R11: The reserved form `inForm`=3 is cracked exactly like a register-register descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fuseEn | input | 1 | 1 = fused cracking, 0 = unfused |
| inValid | input | 1 | Descriptor valid |
| inReady | output | 1 | Cracker idle, descriptor will be taken |
| inForm | input | 2 | Operand form: 0 reg-reg, 1 mem source, 2 mem dest, 3 reserved |
| inOp | input | OPW | ALU opcode |
| inDst | input | REGW | Destination register |
| inSrc | input | REGW | Source register |
| inTag | input | TAGW | Address operand tag |
| outValid | output | 1 | Micro-op valid |
| outReady | input | 1 | Consumer takes the micro-op |
| outKind | output | 3 | Micro-op kind (0 ALU, 1 load, 2 load+ALU, 3 store-address, 4 store-data, 5 fused store) |
| outOp | output | OPW | Opcode carried from the descriptor |
| outDst | output | REGW | Destination register |
| outSrcA | output | REGW | First register operand |
| outSrcB | output | REGW | Second register operand |
| outTag | output | TAGW | Address operand tag |
| outFirst | output | 1 | First micro-op of the instruction |
| outLast | output | 1 | Last micro-op of the instruction |
| outSlots | output | 3 | Reorder-buffer slots the whole instruction uses |

## Verification
The bench builds the cracker with 4-bit opcodes and registers and a 6-bit tag. It overrides the temporary register to 13, so that a design that ignores the parameter is caught. It also sends descriptors that name registers 13 and 15 as their own operands, which puts the temporary next to architectural registers that share its number.

A pseudo-random ready pattern produces stalls on every micro-op position of the four-step sequence. `fuseEn` is flipped right after every accept, which tests the sampling rule. A stretch with `inValid` held high tests back-to-back acceptance against the busy window.

// File: rtl/crk_pkg.sv
package crk_pkg;

  localparam logic [1:0] FORM_RR  = 2'd0;
  localparam logic [1:0] FORM_RM  = 2'd1;
  localparam logic [1:0] FORM_MD  = 2'd2;

  localparam int STEPW = 2;
  localparam int LENW  = 3;

  typedef enum logic [2:0] {
    UK_ALU   = 3'd0,
    UK_LOAD  = 3'd1,
    UK_LDALU = 3'd2,
    UK_STA   = 3'd3,
    UK_STD   = 3'd4,
    UK_STF   = 3'd5
  } uopKind_e;

  typedef struct packed {
    logic             capture;
    logic [STEPW-1:0] stepIdx;
  } crkStrobe_t;

endpackage

// File: rtl/crk_ctrl.sv
module crk_ctrl
  import crk_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic            outReady,
  input  logic [LENW-1:0] seqLen,
  output logic            inReady,
  output logic            outValid,
  output logic            outFirst,
  output logic            outLast,
  output crkStrobe_t      strobe
);

  logic             busy;
  logic [STEPW-1:0] step;

  assign inReady        = !busy;
  assign outValid       = busy;
  assign outFirst       = busy && (step == '0);
  assign outLast        = busy && (LENW'(step) == seqLen - LENW'(1));
  assign strobe.capture = inValid && !busy;
  assign strobe.stepIdx = step;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      step <= '0;
    end else if (strobe.capture) begin
      busy <= 1'b1;
      step <= '0;
    end else if (busy && outReady) begin
      if (outLast) begin
        busy <= 1'b0;
        step <= '0;
      end else begin
        step <= step + STEPW'(1);
      end
    end
  end

  // R8: after the last micro-op is taken, the cracker is free again
  a_r8_release: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> inReady);

  // R8: an accepted descriptor makes the cracker busy
  a_r8_busy: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (outValid && outFirst && !inReady));

  // R9: a stalled micro-op keeps its markers
  a_r9_marks_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outFirst) && $stable(outLast)));

endmodule

// File: rtl/crk_dp.sv
module crk_dp
  import crk_pkg::*;
#(
  parameter int OPW     = 4,
  parameter int REGW    = 4,
  parameter int TAGW    = 6,
  parameter int TMP_REG = 15
) (
  input  logic            clk,
  input  logic            rstN,
  input  crkStrobe_t      strobe,
  input  logic            fuseEn,
  input  logic [1:0]      inForm,
  input  logic [OPW-1:0]  inOp,
  input  logic [REGW-1:0] inDst,
  input  logic [REGW-1:0] inSrc,
  input  logic [TAGW-1:0] inTag,
  output logic [LENW-1:0] seqLen,
  output logic [2:0]      outKind,
  output logic [OPW-1:0]  outOp,
  output logic [REGW-1:0] outDst,
  output logic [REGW-1:0] outSrcA,
  output logic [REGW-1:0] outSrcB,
  output logic [TAGW-1:0] outTag
);

  localparam logic [REGW-1:0] TMP = REGW'(TMP_REG);

  logic            fuseQ;
  logic [1:0]      formQ;
  logic [OPW-1:0]  opQ;
  logic [REGW-1:0] dstQ, srcQ;
  logic [TAGW-1:0] tagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fuseQ <= 1'b0;
      formQ <= FORM_RR;
      opQ   <= '0;
      dstQ  <= '0;
      srcQ  <= '0;
      tagQ  <= '0;
    end else if (strobe.capture) begin
      fuseQ <= fuseEn;
      formQ <= inForm;
      opQ   <= inOp;
      dstQ  <= inDst;
      srcQ  <= inSrc;
      tagQ  <= inTag;
    end
  end

  always_comb begin
    case (formQ)
      FORM_RM: seqLen = fuseQ ? LENW'(1) : LENW'(2);
      FORM_MD: seqLen = fuseQ ? LENW'(2) : LENW'(4);
      default: seqLen = LENW'(1);
    endcase
  end

  assign outOp = opQ;

  always_comb begin
    outKind = UK_ALU;
    outDst  = '0;
    outSrcA = '0;
    outSrcB = '0;
    outTag  = '0;
    case (formQ)
      FORM_RM: begin
        if (fuseQ) begin
          outKind = UK_LDALU; outDst = dstQ; outSrcA = dstQ; outTag = tagQ;
        end else if (strobe.stepIdx == 2'd0) begin
          outKind = UK_LOAD; outDst = TMP; outTag = tagQ;
        end else begin
          outKind = UK_ALU; outDst = dstQ; outSrcA = dstQ; outSrcB = TMP;
        end
      end
      FORM_MD: begin
        if (fuseQ) begin
          if (strobe.stepIdx == 2'd0) begin
            outKind = UK_LDALU; outDst = TMP; outSrcA = srcQ; outTag = tagQ;
          end else begin
            outKind = UK_STF; outSrcB = TMP; outTag = tagQ;
          end
        end else begin
          case (strobe.stepIdx)
            2'd0: begin outKind = UK_LOAD; outDst = TMP; outTag = tagQ; end
            2'd1: begin outKind = UK_ALU; outDst = TMP; outSrcA = TMP; outSrcB = srcQ; end
            2'd2: begin outKind = UK_STA; outTag = tagQ; end
            default: begin outKind = UK_STD; outSrcB = TMP; outTag = tagQ; end
          endcase
        end
      end
      default: begin
        outKind = UK_ALU; outDst = dstQ; outSrcA = dstQ; outSrcB = srcQ;
      end
    endcase
  end

  // R6: store parts never write a register
  a_r6_store_nodst: assert property (@(posedge clk) disable iff (!rstN)
    (outKind inside {UK_STA, UK_STD, UK_STF}) |-> (outDst == '0));

  // R10: the latched mode cannot change while the step is advancing
  a_r10_mode_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.capture && strobe.stepIdx != '0) |=> $stable(seqLen));

endmodule

// File: rtl/memop_cracker.sv
module memop_cracker
  import crk_pkg::*;
#(
  parameter int OPW     = 4,
  parameter int REGW    = 4,
  parameter int TAGW    = 6,
  parameter int TMP_REG = 15
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            fuseEn,
  input  logic            inValid,
  output logic            inReady,
  input  logic [1:0]      inForm,
  input  logic [OPW-1:0]  inOp,
  input  logic [REGW-1:0] inDst,
  input  logic [REGW-1:0] inSrc,
  input  logic [TAGW-1:0] inTag,
  output logic            outValid,
  input  logic            outReady,
  output logic [2:0]      outKind,
  output logic [OPW-1:0]  outOp,
  output logic [REGW-1:0] outDst,
  output logic [REGW-1:0] outSrcA,
  output logic [REGW-1:0] outSrcB,
  output logic [TAGW-1:0] outTag,
  output logic            outFirst,
  output logic            outLast,
  output logic [2:0]      outSlots
);

  crkStrobe_t      strobe;
  logic [LENW-1:0] seqLen;

  crk_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .seqLen   (seqLen),
    .inReady  (inReady),
    .outValid (outValid),
    .outFirst (outFirst),
    .outLast  (outLast),
    .strobe   (strobe)
  );

  crk_dp #(.OPW(OPW), .REGW(REGW), .TAGW(TAGW), .TMP_REG(TMP_REG)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .fuseEn  (fuseEn),
    .inForm  (inForm),
    .inOp    (inOp),
    .inDst   (inDst),
    .inSrc   (inSrc),
    .inTag   (inTag),
    .seqLen  (seqLen),
    .outKind (outKind),
    .outOp   (outOp),
    .outDst  (outDst),
    .outSrcA (outSrcA),
    .outSrcB (outSrcB),
    .outTag  (outTag)
  );

  assign outSlots = seqLen;

  // R7: a stalled micro-op keeps all of its fields
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outKind) && $stable(outDst) &&
      $stable(outSrcA) && $stable(outSrcB) && $stable(outTag) && $stable(outOp)));

  // R9: a single-slot instruction is both first and last
  a_r9_single: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outSlots == 3'd1) |-> (outFirst && outLast));

endmodule

// File: tb/test_memop_cracker.sv
module test_memop_cracker;

  localparam int CLK_PERIOD = 10;
  localparam int OPW = 4, REGW = 4, TAGW = 6, TMPR = 13;

  logic clk = 1'b0, rstN = 1'b0, fuseEn = 1'b1, inValid = 1'b0, outReady = 1'b1;
  logic inReady, outValid, outFirst, outLast;
  logic [1:0] inForm = 2'd0;
  logic [OPW-1:0] inOp = '0, outOp;
  logic [REGW-1:0] inDst = '0, inSrc = '0, outDst, outSrcA, outSrcB;
  logic [TAGW-1:0] inTag = '0, outTag;
  logic [2:0] outKind, outSlots;

  memop_cracker #(.OPW(OPW), .REGW(REGW), .TAGW(TAGW), .TMP_REG(TMPR)) i_memop_cracker (
    .clk(clk), .rstN(rstN), .fuseEn(fuseEn), .inValid(inValid), .inReady(inReady),
    .inForm(inForm), .inOp(inOp), .inDst(inDst), .inSrc(inSrc), .inTag(inTag),
    .outValid(outValid), .outReady(outReady), .outKind(outKind), .outOp(outOp),
    .outDst(outDst), .outSrcA(outSrcA), .outSrcB(outSrcB), .outTag(outTag),
    .outFirst(outFirst), .outLast(outLast), .outSlots(outSlots));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int kind, op, dst, a, b, tag, first, last, slots;
    string req;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0, cycles = 0;
  bit stallOn = 1'b0, done = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic void addUop(int kind, int op, int dst, int a, int b, int tag,
                                 int idx, int n, string req);
    exp_t e;
    e.kind = kind; e.op = op; e.dst = dst; e.a = a; e.b = b; e.tag = tag;
    e.first = (idx == 0); e.last = (idx == n - 1); e.slots = n; e.req = req;
    q.push_back(e);
  endfunction

  // Reference expansion from the requirement text
  function automatic void expand(int form, bit fuse, int op, int d, int s, int t);
    if (form == 1 && fuse) begin
      addUop(2, op, d, d, 0, t, 0, 1, "R3");
    end else if (form == 1) begin
      addUop(1, op, TMPR, 0, 0, t, 0, 2, "R4");
      addUop(0, op, d, d, TMPR, 0, 1, 2, "R4");
    end else if (form == 2 && fuse) begin
      addUop(2, op, TMPR, s, 0, t, 0, 2, "R5");
      addUop(5, op, 0, 0, TMPR, t, 1, 2, "R5");
    end else if (form == 2) begin
      addUop(1, op, TMPR, 0, 0, t, 0, 4, "R6");
      addUop(0, op, TMPR, TMPR, s, 0, 1, 4, "R6");
      addUop(3, op, 0, 0, 0, t, 2, 4, "R6");
      addUop(4, op, 0, 0, TMPR, t, 3, 4, "R6");
    end else begin
      addUop(0, op, d, d, s, 0, 0, 1, form == 3 ? "R11" : "R2");
    end
  endfunction

  // Reference model update on every clock edge
  always @(posedge clk) begin
    bit acc;
    if (!rstN) q.delete();
    else begin
      acc = (q.size() == 0) && inValid;
      if (q.size() > 0 && outReady) void'(q.pop_front());
      if (acc) expand(int'(inForm), fuseEn, int'(inOp), int'(inDst), int'(inSrc), int'(inTag));
    end
  end

  // Compare away from the active edge
  logic prevStall = 1'b0;
  int prevKind = 0, prevDst = 0, prevTag = 0, prevB = 0;
  always @(negedge clk) begin
    if (!rstN) begin
      chk(outValid == 1'b0, "R1", "outValid in reset", int'(outValid), 0);
      chk(inReady == 1'b1, "R1", "inReady in reset", int'(inReady), 1);
      prevStall = 1'b0;
    end else if (!done) begin
      chk(outValid == (q.size() > 0), "R8", "outValid", int'(outValid), int'(q.size() > 0));
      chk(inReady == (q.size() == 0), "R8", "inReady", int'(inReady), int'(q.size() == 0));
      if (prevStall) begin
        chk(int'(outKind) == prevKind && int'(outDst) == prevDst &&
            int'(outTag) == prevTag && int'(outSrcB) == prevB,
            "R7", "held kind", int'(outKind), prevKind);
      end
      if (q.size() > 0) begin
        chk(int'(outKind) == q[0].kind, q[0].req, "kind", int'(outKind), q[0].kind);
        chk(int'(outOp) == q[0].op, q[0].req, "op", int'(outOp), q[0].op);
        chk(int'(outDst) == q[0].dst, q[0].req, "dst", int'(outDst), q[0].dst);
        chk(int'(outSrcA) == q[0].a, q[0].req, "srcA", int'(outSrcA), q[0].a);
        chk(int'(outSrcB) == q[0].b, q[0].req, "srcB", int'(outSrcB), q[0].b);
        chk(int'(outTag) == q[0].tag, q[0].req, "tag", int'(outTag), q[0].tag);
        chk(int'(outSlots) == q[0].slots, q[0].req, "slots", int'(outSlots), q[0].slots);
        chk(int'(outFirst) == q[0].first, "R9", "first", int'(outFirst), q[0].first);
        chk(int'(outLast) == q[0].last, "R9", "last", int'(outLast), q[0].last);
      end
    end
  end

  // Ready pattern and stall tracking
  always @(posedge clk) begin
    prevStall <= outValid && !outReady && rstN;
    prevKind <= int'(outKind); prevDst <= int'(outDst);
    prevTag <= int'(outTag); prevB <= int'(outSrcB);
  end
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    outReady <= stallOn ? (lfsr[0] | (lfsr[1] & lfsr[2])) : 1'b1;
  end

  // Send one descriptor, then flip the mode to test R10
  task automatic send(int form, bit fuse, int op, int d, int s, int t);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1'b1; inForm = 2'(form); fuseEn = fuse;
    inOp = OPW'(op); inDst = REGW'(d); inSrc = REGW'(s); inTag = TAGW'(t);
    @(negedge clk);
    inValid = 1'b0;
    fuseEn = !fuse;           // R10: must not affect the running sequence
    inForm = 2'd2; inDst = 4'hF;  // R8: garbage while busy is ignored
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int pass = 0; pass < 2; pass++) begin
      stallOn = (pass == 1);
      for (int f = 0; f < 4; f++) begin
        send(f, 1'b1, 3 + f, 2 + f, 5 + f, 10 + f);      // R2 R3 R5 R11 fused
        send(f, 1'b0, 9 - f, 7 - f, 1 + f, 40 + f);      // R2 R4 R6 R11 unfused
      end
      send(2, 1'b0, 15, 13, 15, 63);                     // R6 operands near TMP
      send(1, 1'b0, 1, 15, 13, 1);                       // R4
      send(2, 1'b1, 6, 0, 13, 0);                        // R5
    end
    // R8: inValid held high, back-to-back acceptance
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1'b1; inForm = 2'd2; fuseEn = 1'b0; inOp = 4'd4;
    inDst = 4'd3; inSrc = 4'd6; inTag = 6'd21;
    repeat (40) @(negedge clk);
    inValid = 1'b0;
    repeat (40) @(negedge clk);
    finishRun();
  end

endmodule